// File: doc/BRIEF.md
# Masked Block-Write Memory Datapath

This block is the write path in front of a 16-bit-wide memory array, modelled as on-chip registers. A synchronous command port carries an opcode, a row, a column, a data word and two byte enables. Normal writes store the data word at one location. Block writes copy a stored colour word into any chosen subset of an aligned group of adjacent columns in a single cycle. Two load cycles update the persistent write-mask register and the colour register.

Every write that reaches the array is qualified bit by bit. The byte enables pick the bytes, and the stored mask can protect individual bits when the command's mask-enable flag is set. The mask is persistent, so once loaded it governs every later masked write until it is reloaded. A read opcode returns one word through a registered output. This makes the array contents visible at the ports.

The full organisation is 512 rows by 512 columns, giving 262144 words (ROW_W=9, COL_W=9). The defaults are smaller (ROW_W=4, COL_W=6) so that the register model stays compact. GROUP selects a 4-column or an 8-column block write.

Top module: `mbw_block_write`

## Requirements
- R1: After reset every array word reads 0, the mask register is all ones and the colour register is 0.
- R2: The opcodes are 0 = idle, 1 = write, 2 = block write, 3 = load mask, 4 = load colour and 5 = read. A write stores data_i at word row_i*2^COL_W + col_i, subject to R4 to R6.
- R3: A block write selects the group that starts at col_i with its low log2(GROUP) bits cleared. Data bit i (i < GROUP) enables column base+i of that group, and the colour word is written there. Columns whose bit is 0, columns outside the group, and data bits at or above GROUP have no effect. No more than GROUP words change in one cycle.
- R4: When mask_en_i is 1 on a write or block write, a bit is written only if its mask bit is 1. A mask bit of 0 leaves that array bit unchanged.
- R5: When mask_en_i is 0 on a write or block write, the stored mask is ignored.
- R6: be_i[0] enables bits 7:0 and be_i[1] enables bits 15:8. A disabled byte is left unchanged on a write, a block write, a load-mask cycle and a load-colour cycle.
- R7: A load-mask cycle replaces the enabled bytes of the mask with data_i and does not change the array.
- R8: A load-colour cycle replaces the enabled bytes of the colour register with data_i and does not change the array.
- R9: The mask register keeps its value across every command other than load mask.
- R10: A read raises rd_valid_o for exactly one cycle, on the clock after the command, with the addressed word on rd_data_o. When cmd_valid_i is low, the command has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command qualifier |
| cmd_op_i | input | 3 | Opcode (see R2) |
| mask_en_i | input | 1 | Apply the stored mask on this write |
| row_i | input | ROW_W | Row address |
| col_i | input | COL_W | Column address |
| data_i | input | 16 | Write data, column select for block writes, or register load value |
| be_i | input | 2 | Byte enables, bit 0 for the low byte |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 16 | Read data |

## Verification
The hardest case to reach is a block write in which the mask, the byte enables and a sparse column pattern all overlap. Reaching it needs a partial mask load, a partial colour load and then a block write with an unaligned column and stray high data bits, before the words can be read back. The directed sequence builds exactly that. A long random run of mixed loads, writes and reads follows, and a behavioural model checks every read and every valid flag on each clock.

// File: rtl/mbw_pkg.sv
package mbw_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned NBYTES = 2;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_WRITE    = 3'd1,
    OP_BLOCK    = 3'd2,
    OP_LD_MASK  = 3'd3,
    OP_LD_COLOR = 3'd4,
    OP_READ     = 3'd5
  } op_e;

  function automatic logic [DATA_W-1:0] byte_bits(input logic [NBYTES-1:0] be);
    logic [DATA_W-1:0] r;
    for (int b = 0; b < NBYTES; b++) r[b*8 +: 8] = {8{be[b]}};
    return r;
  endfunction
endpackage

// File: rtl/mbw_bitsel.sv
module mbw_bitsel
  import mbw_pkg::*;
(
  input  logic [NBYTES-1:0] be_i,
  input  logic              mask_en_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] bit_en_o
);
  always_comb begin
    bit_en_o = byte_bits(be_i);
    if (mask_en_i) bit_en_o = bit_en_o & mask_i;
  end
endmodule

// File: rtl/mbw_regs.sv
module mbw_regs
  import mbw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_mask_i,
  input  logic              ld_color_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] byte_en_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] color_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o  <= '1;
      color_o <= '0;
    end else begin
      if (ld_mask_i)  mask_o  <= (mask_o  & ~byte_en_i) | (data_i & byte_en_i);
      if (ld_color_i) color_o <= (color_o & ~byte_en_i) | (data_i & byte_en_i);
    end
  end
endmodule

// File: rtl/mbw_array.sv
module mbw_array
  import mbw_pkg::*;
#(
  parameter int unsigned ROW_W = 4,
  parameter int unsigned COL_W = 6,
  parameter int unsigned GROUP = 4,
  localparam int unsigned GB    = $clog2(GROUP),
  localparam int unsigned COLS  = 1 << COL_W,
  localparam int unsigned WORDS = 1 << (ROW_W + COL_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [GROUP-1:0]  lane_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bit_en_i,
  input  logic              rd_en_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [WORDS-1:0]  hits_o
);
  logic [DATA_W-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam int unsigned RI = w / COLS;
    localparam int unsigned GI = (w % COLS) / GROUP;
    localparam int unsigned LI = w % GROUP;
    logic [DATA_W-1:0] word_q;

    assign hits_o[w] = we_i && (row_i == ROW_W'(RI))
                     && (col_i[COL_W-1:GB] == (COL_W-GB)'(GI))
                     && lane_en_i[LI];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        word_q <= '0;
      else if (hits_o[w]) word_q <= (word_q & ~bit_en_i) | (wdata_i & bit_en_i);
    end
    assign words[w] = word_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= words[{row_i, col_i}];
    end
  end
endmodule

// File: rtl/mbw_block_write.sv
module mbw_block_write
  import mbw_pkg::*;
#(
  parameter int unsigned ROW_W = 4,
  parameter int unsigned COL_W = 6,
  parameter int unsigned GROUP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic              mask_en_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [NBYTES-1:0] be_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned GB    = $clog2(GROUP);
  localparam int unsigned WORDS = 1 << (ROW_W + COL_W);

  op_e               op;
  logic              is_wr, is_blk, is_ldm, is_ldc, is_rd;
  logic [DATA_W-1:0] mask_q, color_q, bit_en, load_en, wdata;
  logic [GROUP-1:0]  lane_en;
  logic [WORDS-1:0]  word_hits;

  assign op     = op_e'(cmd_op_i);
  assign is_wr  = cmd_valid_i && (op == OP_WRITE);
  assign is_blk = cmd_valid_i && (op == OP_BLOCK);
  assign is_ldm = cmd_valid_i && (op == OP_LD_MASK);
  assign is_ldc = cmd_valid_i && (op == OP_LD_COLOR);
  assign is_rd  = cmd_valid_i && (op == OP_READ);

  // normal write: one-hot lane from column; block write: lanes from data bus
  always_comb begin
    lane_en = '0;
    if (is_blk)     lane_en = data_i[GROUP-1:0];
    else if (is_wr) lane_en[col_i[GB-1:0]] = 1'b1;
  end

  assign wdata   = is_blk ? color_q : data_i;
  assign load_en = byte_bits(be_i);

  mbw_bitsel u_bitsel (
    .be_i      (be_i),
    .mask_en_i (mask_en_i),
    .mask_i    (mask_q),
    .bit_en_o  (bit_en)
  );

  mbw_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_mask_i  (is_ldm),
    .ld_color_i (is_ldc),
    .data_i     (data_i),
    .byte_en_i  (load_en),
    .mask_o     (mask_q),
    .color_o    (color_q)
  );

  mbw_array #(.ROW_W(ROW_W), .COL_W(COL_W), .GROUP(GROUP)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (is_wr || is_blk),
    .row_i      (row_i),
    .col_i      (col_i),
    .lane_en_i  (lane_en),
    .wdata_i    (wdata),
    .bit_en_i   (bit_en),
    .rd_en_i    (is_rd),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .hits_o     (word_hits)
  );
endmodule

// File: rtl/mbw_block_write_chk.sv
module mbw_block_write_chk
  import mbw_pkg::*;
#(
  parameter int unsigned GROUP = 4,
  parameter int unsigned WORDS = 1024
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [2:0]        cmd_op_i,
  input logic [DATA_W-1:0] data_i,
  input logic [NBYTES-1:0] be_i,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] mask_q,
  input logic [DATA_W-1:0] color_q,
  input logic [WORDS-1:0]  word_hits
);
  logic ldm, ldc, rdc;
  assign ldm = cmd_valid_i && (cmd_op_i == OP_LD_MASK);
  assign ldc = cmd_valid_i && (cmd_op_i == OP_LD_COLOR);
  assign rdc = cmd_valid_i && (cmd_op_i == OP_READ);

  initial assert_group_size_R3: assert (GROUP == 4 || GROUP == 8);

  assert_rd_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rdc));

  assert_rd_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdc |=> rd_valid_o);

  assert_ld_mask_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldm && be_i == 2'b11) |=> mask_q == $past(data_i));

  assert_ld_no_array_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldm || rdc) |-> word_hits == '0);

  assert_ld_color_no_array_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ldc |-> word_hits == '0);

  assert_color_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ldc |=> $stable(color_q));

  assert_mask_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ldm |=> $stable(mask_q));

  assert_group_limit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(word_hits) <= GROUP);
endmodule

bind mbw_block_write mbw_block_write_chk #(
  .GROUP (GROUP),
  .WORDS (1 << (ROW_W + COL_W))
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .data_i      (data_i),
  .be_i        (be_i),
  .rd_valid_o  (rd_valid_o),
  .mask_q      (mask_q),
  .color_q     (color_q),
  .word_hits   (word_hits)
);

// File: tb/mbw_block_write_tb_top.sv
module mbw_block_write_tb_top;
  localparam int ROW_W = 4;
  localparam int COL_W = 6;
  localparam int GROUP = 4;
  localparam int COLS  = 1 << COL_W;
  localparam int WORDS = 1 << (ROW_W + COL_W);
  localparam int OP_NOP = 0, OP_WR = 1, OP_BLK = 2, OP_LDM = 3, OP_LDC = 4, OP_RD = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [2:0]        cmd_op = '0;
  logic              mask_en = 1'b0;
  logic [ROW_W-1:0]  row = '0;
  logic [COL_W-1:0]  col = '0;
  logic [15:0]       data = '0;
  logic [1:0]        be = '0;
  logic              rd_valid;
  logic [15:0]       rd_data;

  logic [15:0] ref_mem [WORDS];
  logic [15:0] ref_mask, ref_color;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mbw_block_write #(.ROW_W(ROW_W), .COL_W(COL_W), .GROUP(GROUP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .mask_en_i(mask_en), .row_i(row), .col_i(col), .data_i(data), .be_i(be),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  function automatic logic [15:0] bytes16(input logic [1:0] b);
    return {{8{b[1]}}, {8{b[0]}}};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmd(input bit v, input int op, input bit men, input int r, input int c,
                     input logic [15:0] d, input logic [1:0] b, input string tag);
    logic [15:0] exp_rd, wm;
    int idx, base;
    @(negedge clk);
    cmd_valid = v; cmd_op = 3'(op); mask_en = men; row = ROW_W'(r); col = COL_W'(c);
    data = d; be = b;
    idx = r * COLS + c;
    exp_rd = ref_mem[idx];
    @(posedge clk);
    #2;
    check(rd_valid == (v && op == OP_RD), {tag, " valid R10"}, 16'(rd_valid), 16'(v && op == OP_RD));
    if (v && op == OP_RD) check(rd_data == exp_rd, tag, rd_data, exp_rd);
    wm = bytes16(b) & (men ? ref_mask : 16'hFFFF);
    if (v) begin
      case (op)
        OP_WR:  ref_mem[idx] = (ref_mem[idx] & ~wm) | (d & wm);
        OP_BLK: begin
          base = r * COLS + (c & ~(GROUP - 1));
          for (int i = 0; i < GROUP; i++)
            if (d[i]) ref_mem[base + i] = (ref_mem[base + i] & ~wm) | (ref_color & wm);
        end
        OP_LDM: ref_mask  = (ref_mask  & ~bytes16(b)) | (d & bytes16(b));
        OP_LDC: ref_color = (ref_color & ~bytes16(b)) | (d & bytes16(b));
        default: ;
      endcase
    end
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input int r, input int c, input string tag);
    cmd(1, OP_RD, 0, r, c, 16'h0, 2'b00, tag);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
    ref_mask = 16'hFFFF;
    ref_color = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(0, 0, "R1 reset word");
    rd(15, 63, "R1 reset word");
    cmd(1, OP_WR, 0, 2, 8, 16'hAAAA, 2'b11, "R1");
    cmd(1, OP_BLK, 0, 2, 8, 16'h0001, 2'b11, "R1 colour reset");
    rd(2, 8, "R1 colour zero after reset");
    cmd(1, OP_WR, 1, 2, 9, 16'h5A5A, 2'b11, "R1");
    rd(2, 9, "R1 mask all ones after reset");

    // R2 normal writes
    cmd(1, OP_WR, 0, 3, 5, 16'h1234, 2'b11, "R2");
    cmd(1, OP_WR, 0, 7, 62, 16'hFEDC, 2'b11, "R2");
    rd(3, 5, "R2 write readback");
    rd(7, 62, "R2 write readback");
    rd(3, 4, "R2 neighbour untouched");

    // R10 invalid command ignored
    cmd(0, OP_WR, 0, 3, 5, 16'hDEAD, 2'b11, "R10");
    rd(3, 5, "R10 invalid write ignored");

    // R8 colour loads, byte-partial
    cmd(1, OP_LDC, 0, 3, 5, 16'hC3C3, 2'b11, "R8");
    cmd(1, OP_LDC, 0, 3, 5, 16'hFF56, 2'b01, "R8");
    rd(3, 5, "R8 array unchanged by colour load");

    // R3 block write, unaligned column, stray high bits
    for (int c = 12; c < 20; c++) cmd(1, OP_WR, 0, 4, c, 16'h1111, 2'b11, "R3");
    cmd(1, OP_BLK, 0, 4, 13, 16'hFFF5, 2'b11, "R3");
    for (int c = 11; c < 20; c++) rd(4, c, "R3 block write group");
    cmd(1, OP_BLK, 0, 5, 3, 16'h000F, 2'b11, "R3");
    for (int c = 0; c < 5; c++) rd(5, c, "R3 full group");

    // R7 mask loads, R4 masked write, R5 unmasked, R9 persistence
    cmd(1, OP_LDM, 0, 3, 5, 16'h0F0F, 2'b11, "R7");
    rd(3, 5, "R7 array unchanged by mask load");
    cmd(1, OP_WR, 1, 6, 0, 16'hFFFF, 2'b11, "R4");
    rd(6, 0, "R4 masked write");
    cmd(1, OP_WR, 0, 6, 1, 16'hFFFF, 2'b11, "R5");
    rd(6, 1, "R5 mask ignored");
    cmd(1, OP_BLK, 0, 6, 2, 16'h0004, 2'b11, "R9");
    cmd(1, OP_WR, 1, 6, 3, 16'hABCD, 2'b11, "R9");
    rd(6, 3, "R9 mask persists");
    cmd(1, OP_LDM, 0, 0, 0, 16'hF0AA, 2'b10, "R7");
    cmd(1, OP_WR, 1, 6, 4, 16'hFFFF, 2'b11, "R7");
    rd(6, 4, "R7 partial mask load");

    // R6 byte enables on write and block write
    cmd(1, OP_WR, 0, 8, 8, 16'hFFFF, 2'b01, "R6");
    rd(8, 8, "R6 low byte only");
    cmd(1, OP_WR, 0, 8, 9, 16'hFFFF, 2'b10, "R6");
    rd(8, 9, "R6 high byte only");
    cmd(1, OP_WR, 0, 8, 10, 16'hFFFF, 2'b00, "R6");
    rd(8, 10, "R6 no byte");
    cmd(1, OP_LDC, 0, 0, 0, 16'hFFFF, 2'b11, "R6");
    cmd(1, OP_BLK, 1, 8, 12, 16'h0009, 2'b10, "R6");
    for (int c = 12; c < 16; c++) rd(8, c, "R6 R4 block write byte and mask");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom_range(0, 5);
      cmd($urandom_range(0, 7) != 0, op, 1'($urandom), $urandom_range(0, 15), $urandom_range(0, 63),
          16'($urandom), 2'($urandom), "R2 R3 R4 R6 random");
    end
    for (int i = 0; i < WORDS; i += 7) rd(i / COLS, i % COLS, "R3 R4 random sweep");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule